// File: doc/BRIEF.md
# Burst Receive FIFO Read Port

This block is the host-side read window onto a serial receiver's byte FIFO. Received bytes enter on a simple valid/data strobe, together with per-byte parity and framing error flags. Software drains the FIFO over a register strobe interface. It can pull up to four bytes with one 32-bit read of the burst data register. The tail of fewer than four bytes comes out one at a time through the byte data register.

A single read-only status word combines three things: the number of bytes held, an active-low interrupt-pending flag and a line-status byte. The line-status byte carries data-ready, overrun, parity and framing indications. Software reads the status word first, takes as many bursts as the count allows, then finishes with byte reads. An overrun stays flagged until software writes the clear code to the FIFO control register. The FIFO depth must be a power of two, at least four and at most 255. The interrupt threshold must not exceed the depth.

Register offsets (byte addresses on `bus_addr`): status 0x0, byte data 0x4, burst data 0x8, FIFO control 0xC.

Top module: `rxb_burst_port`

## Requirements
- R1: Status bits 7:0 give the number of bytes held in the FIFO, which never exceeds DEPTH; with no byte arriving and no read, the count does not change.
- R2: Status bit 24 (data ready) is 1 exactly when the count is nonzero.
- R3: Status bit 20 is 1 when no interrupt is pending. An interrupt is pending when the count is at least TRIG_LEVEL or any of the overrun, parity or framing flags is set.
- R4: A read of the burst register (0x8) pops min(4, count) bytes and returns them little-endian, oldest byte in bits 7:0; lanes without a byte read as zero.
- R5: A read of the byte register (0x4) pops one byte and returns it in bits 7:0 with bits 31:8 zero; on an empty FIFO it returns zero and pops nothing.
- R6: A byte arriving while the FIFO holds DEPTH bytes is dropped and sets the overrun flag (status bit 25), which a status read does not clear.
- R7: A write of exactly 0x00000043 to the control register (0xC) clears the overrun flag; other values or other offsets leave it set; an overrun in the same cycle wins.
- R8: An accepted byte with its parity or framing flag high sets status bit 26 or bit 27 respectively. A status read returns these flags and then clears them, but an error arriving in the same cycle leaves its flag set.
- R9: Read data and `bus_rvalid` appear on the clock edge after the `bus_rd` strobe; reads of the control register or unmapped offsets return zero and pop nothing.
- R10: Status bits 31:28, 23:21 and 19:8 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_byte | input | 8 | Received byte |
| rx_parity_err | input | 1 | Parity error on the offered byte |
| rx_frame_err | input | 1 | Framing error on the offered byte |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |

## Verification
The assertions rely on the receive side and the host side being free-running strobes that may both be active in the same cycle as read, write and byte arrival. Any offset may be presented, including unmapped ones. The stimulus stays within this by driving every input only at the falling edge. Offsets are drawn mostly from the four mapped registers, with a share of arbitrary values. Byte arrival is biased in phases so that the FIFO both runs dry and overflows repeatedly, which exercises the overrun and partial-burst properties.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int LANES   = 4;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = LANES * BYTE_W;
  localparam int POP_W   = $clog2(LANES + 1);

  localparam int OFS_STATUS = 0;
  localparam int OFS_BYTE   = 4;
  localparam int OFS_BURST  = 8;
  localparam int OFS_CTRL   = 12;

  localparam logic [WORD_W-1:0] OVR_CLEAR_CODE = 32'h0000_0043;

  localparam int BIT_NO_INT = 20;
  localparam int BIT_READY  = 24;
  localparam int BIT_OVR    = 25;
  localparam int BIT_PAR    = 26;
  localparam int BIT_FRM    = 27;

  typedef struct packed {
    logic frm;
    logic par;
    logic ovr;
  } line_flags_t;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo import rxb_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [BYTE_W-1:0]          wdata,
  input  logic [POP_W-1:0]           pop_n,
  output logic [WORD_W-1:0]          window,
  output logic [$clog2(DEPTH):0]     fill,
  output logic                       full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      rd_ptr <= rd_ptr + PTR_W'(pop_n);
      fill   <= fill + CNT_W'(push) - CNT_W'(pop_n);
    end
  end

  assign full = (fill == CNT_W'(DEPTH));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PTR_W-1:0] idx;
    assign idx = rd_ptr + PTR_W'(k);
    assign window[k*BYTE_W +: BYTE_W] = (fill > CNT_W'(k)) ? mem[idx] : '0;
  end
endmodule

// File: rtl/rxb_line_flags.sv
module rxb_line_flags import rxb_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        set_ovr,
  input  logic        clr_ovr,
  input  logic        set_par,
  input  logic        set_frm,
  input  logic        clr_err,
  output line_flags_t flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      flags.ovr <= set_ovr | (flags.ovr & ~clr_ovr);
      flags.par <= set_par | (flags.par & ~clr_err);
      flags.frm <= set_frm | (flags.frm & ~clr_err);
    end
  end
endmodule

// File: rtl/rxb_burst_port.sv
module rxb_burst_port import rxb_pkg::*; #(
  parameter int DEPTH      = 16,
  parameter int TRIG_LEVEL = 8,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_parity_err,
  input  logic              rx_frame_err,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic [CNT_W-1:0]  fill;
  logic              full;
  logic [WORD_W-1:0] window;
  logic [POP_W-1:0]  pop_n;
  logic              push;
  line_flags_t       flags;
  logic              oe_flag;
  logic              rd_stat, rd_byte, rd_burst, wr_ctrl;
  logic              irq_pend;
  logic [WORD_W-1:0] status_word;

  assign rd_stat  = bus_rd && (bus_addr == ADDR_W'(OFS_STATUS));
  assign rd_byte  = bus_rd && (bus_addr == ADDR_W'(OFS_BYTE));
  assign rd_burst = bus_rd && (bus_addr == ADDR_W'(OFS_BURST));
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));

  assign push = rx_valid && !full;

  always_comb begin
    pop_n = '0;
    if (rd_byte && fill != '0)
      pop_n = POP_W'(1);
    else if (rd_burst)
      pop_n = (fill >= CNT_W'(LANES)) ? POP_W'(LANES) : POP_W'(fill);
  end

  rxb_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk    (clk),
    .rst    (rst),
    .push   (push),
    .wdata  (rx_byte),
    .pop_n  (pop_n),
    .window (window),
    .fill   (fill),
    .full   (full)
  );

  rxb_line_flags i_flags (
    .clk     (clk),
    .rst     (rst),
    .set_ovr (rx_valid && full),
    .clr_ovr (wr_ctrl && bus_wdata == OVR_CLEAR_CODE),
    .set_par (push && rx_parity_err),
    .set_frm (push && rx_frame_err),
    .clr_err (rd_stat),
    .flags   (flags)
  );

  assign oe_flag  = flags.ovr;
  assign irq_pend = (fill >= CNT_W'(TRIG_LEVEL)) || flags.ovr || flags.par || flags.frm;

  always_comb begin
    status_word             = '0;
    status_word[7:0]        = 8'(fill);
    status_word[BIT_NO_INT] = !irq_pend;
    status_word[BIT_READY]  = (fill != '0);
    status_word[BIT_OVR]    = flags.ovr;
    status_word[BIT_PAR]    = flags.par;
    status_word[BIT_FRM]    = flags.frm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        if (rd_stat)       bus_rdata <= status_word;
        else if (rd_byte)  bus_rdata <= {24'b0, window[7:0]};
        else if (rd_burst) bus_rdata <= window;
        else               bus_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/rxb_burst_port_chk.sv
module rxb_burst_port_chk #(
  parameter int DEPTH      = 16,
  parameter int TRIG_LEVEL = 8,
  parameter int ADDR_W     = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rx_valid,
  input logic                    bus_rd,
  input logic                    bus_wr,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [31:0]             bus_wdata,
  input logic [31:0]             bus_rdata,
  input logic                    bus_rvalid,
  input logic [$clog2(DEPTH):0]  fill,
  input logic                    oe_flag
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(DEPTH));

  assert_fill_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !bus_rd) |=> $stable(fill));

  assert_ready_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr) == ADDR_W'(0)) |-> (bus_rdata[24] == (bus_rdata[7:0] != 8'd0)));

  assert_irq_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr) == ADDR_W'(0)) |->
      (bus_rdata[20] == !((bus_rdata[7:0] >= 8'(TRIG_LEVEL)) || (|bus_rdata[27:25]))));

  assert_ovr_set_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && fill == CNT_W'(DEPTH)) |=> oe_flag);

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (oe_flag && !(bus_wr && bus_addr == ADDR_W'(12) && bus_wdata == 32'h43)) |=> oe_flag);

  assert_rvalid_R9: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  assert_rvalid_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr) == ADDR_W'(0)) |-> ((bus_rdata & 32'hF0EF_FF00) == 32'h0));
endmodule

bind rxb_burst_port rxb_burst_port_chk #(
  .DEPTH(DEPTH), .TRIG_LEVEL(TRIG_LEVEL), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .fill(fill), .oe_flag(oe_flag)
);

// File: tb/test_rxb_burst_port.sv
module test_rxb_burst_port;
  localparam int DEPTH = 16;
  localparam int TRIG  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_parity_err = 1'b0;
  logic        rx_frame_err = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  rxb_burst_port #(.DEPTH(DEPTH), .TRIG_LEVEL(TRIG), .ADDR_W(4)) i_rxb_burst_port (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  byte unsigned q[$];
  bit m_oe, m_pe, m_fe;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    bit pend;
    pend = (q.size() >= TRIG) || m_oe || m_pe || m_fe;
    s = '0;
    s[7:0] = 8'(q.size());
    s[20] = !pend;
    s[24] = (q.size() != 0);
    s[25] = m_oe;
    s[26] = m_pe;
    s[27] = m_fe;
    return s;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    logic [31:0] w;
    w = '0;
    case (a)
      4'h0: w = exp_status();
      4'h4: if (q.size() > 0) w[7:0] = q[0];
      4'h8: for (int k = 0; k < 4; k++) if (k < q.size()) w[k*8 +: 8] = q[k];
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic step(input bit v, input byte unsigned d, input bit pe, input bit fe,
                      input bit rd, input logic [3:0] a, input bit wr,
                      input logic [31:0] wd, input string tag);
    logic [31:0] expv;
    int n;
    bit accept;
    @(negedge clk);
    rx_valid = v; rx_byte = d; rx_parity_err = pe; rx_frame_err = fe;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    expv = exp_read(a);
    n = q.size();
    @(posedge clk);
    #1;
    check(bus_rvalid == rd, {tag, " R9 rvalid"}, 32'(bus_rvalid), 32'(rd));
    if (rd) check(bus_rdata == expv, tag, bus_rdata, expv);
    accept = v && (n < DEPTH);
    if (rd && a == 4'h4 && n > 0) void'(q.pop_front());
    if (rd && a == 4'h8) for (int k = 0; k < 4 && k < n; k++) void'(q.pop_front());
    if (rd && a == 4'h0) begin m_pe = 0; m_fe = 0; end
    if (wr && a == 4'hC && wd == 32'h43) m_oe = 0;
    if (v && n == DEPTH) m_oe = 1;
    if (accept) begin
      q.push_back(d);
      if (pe) m_pe = 1;
      if (fe) m_fe = 1;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 4'h0, 0, 0, "idle");
  endtask

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'h0: return "R1 R2 R3 R6 R8 R10 status";
      4'h4: return "R5 byte read";
      4'h8: return "R4 burst read";
      default: return "R9 unmapped or control read";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    m_oe = 0; m_pe = 0; m_fe = 0;
    repeat (3) @(posedge clk);
    #1;
    check(bus_rvalid == 1'b0, "R9 reset rvalid", 32'(bus_rvalid), 0);
    @(negedge clk);
    rst = 1'b0;

    step(0, 0, 0, 0, 1, 4'h0, 0, 0, "R1 R2 R3 R10 reset status");
    for (int i = 0; i < 6; i++) step(1, 8'h11 + 8'(i), 0, 0, 0, 4'h0, 0, 0, "push");
    step(0, 0, 0, 0, 1, 4'h0, 0, 0, "R1 R2 count six");
    step(0, 0, 0, 0, 1, 4'h8, 0, 0, "R4 full burst little-endian");
    step(0, 0, 0, 0, 1, 4'h8, 0, 0, "R4 partial burst zero lanes");
    step(0, 0, 0, 0, 1, 4'h4, 0, 0, "R5 byte read empty");
    step(0, 0, 0, 0, 1, 4'h0, 0, 0, "R1 R2 drained");
    for (int i = 0; i < 3; i++) step(1, 8'hA0 + 8'(i), 0, 0, 0, 4'h0, 0, 0, "push");
    step(0, 0, 0, 0, 1, 4'h4, 0, 0, "R5 byte read");
    step(0, 0, 0, 0, 1, 4'h2, 0, 0, "R9 unmapped read");
    step(0, 0, 0, 0, 1, 4'hC, 0, 0, "R9 control read");
    step(0, 0, 0, 0, 1, 4'h4, 0, 0, "R5 byte read");
    step(0, 0, 0, 0, 1, 4'h0, 0, 0, "R1 R2 after byte reads");
    for (int i = 0; i < DEPTH + 1; i++) step(1, 8'(i), 0, 0, 0, 4'h0, 0, 0, "push to full");
    step(0, 0, 0, 0, 1, 4'h0, 0, 0, "R6 R3 overrun set");
    step(0, 0, 0, 0, 1, 4'h0, 0, 0, "R6 overrun sticky over status read");
    step(0, 0, 0, 0, 0, 4'hC, 1, 32'h42, "write");
    step(0, 0, 0, 0, 0, 4'h4, 1, 32'h43, "write");
    step(0, 0, 0, 0, 1, 4'h0, 0, 0, "R7 other value or offset ignored");
    step(0, 0, 0, 0, 0, 4'hC, 1, 32'h43, "write");
    step(0, 0, 0, 0, 1, 4'h0, 0, 0, "R7 overrun cleared");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 4'h8, 0, 0, "R4 drain burst");
    step(1, 8'h5A, 1, 0, 0, 4'h0, 0, 0, "push parity");
    step(1, 8'h5B, 0, 1, 1, 4'h0, 0, 0, "R8 parity set");
    step(0, 0, 0, 0, 1, 4'h0, 0, 0, "R8 framing wins over clear");
    step(0, 0, 0, 0, 1, 4'h0, 0, 0, "R8 flags cleared");
    step(0, 0, 0, 0, 1, 4'h8, 0, 0, "R4 drain");
    for (int i = 0; i < TRIG - 1; i++) step(1, 8'hC0 + 8'(i), 0, 0, 0, 4'h0, 0, 0, "push");
    step(0, 0, 0, 0, 1, 4'h0, 0, 0, "R3 below trigger");
    step(1, 8'hCF, 0, 0, 0, 4'h0, 0, 0, "push");
    step(0, 0, 0, 0, 1, 4'h0, 0, 0, "R3 at trigger");

    for (int c = 0; c < 4000; c++) begin
      bit v, pe, fe, rd, wr;
      logic [3:0] a;
      logic [31:0] wd;
      int bias;
      bias = ((c / 200) % 2 == 0) ? 75 : 25;
      v  = ($urandom % 100) < bias;
      pe = ($urandom % 100) < 8;
      fe = ($urandom % 100) < 8;
      rd = ($urandom % 100) < 45;
      wr = ($urandom % 100) < 8;
      if (($urandom % 100) < 85) a = 4'(($urandom % 4) * 4);
      else a = 4'($urandom);
      wd = (($urandom % 2) == 0) ? 32'h43 : $urandom;
      step(v, 8'($urandom), pe, fe, rd, a, wr, wd, tag_of(a));
    end
    idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule